// File: doc/BRIEF.md
# Top-Two Margin Confidence Checker

This block sits after the last layer of a classifier. It takes the raw signed score of each class, one per cycle. A last flag marks the final score of an image. The block keeps a running maximum, a running runner-up and the position of the maximum. When the image ends it reports the winning class and the gap between the two best scores. It also reports whether that gap is large enough to trust the prediction. No softmax is applied, because only the order of the scores and their difference matter.

A downstream scheduler uses the confident flag. A confident prediction from a fast, low-precision network can be accepted as final. A non-confident one sends the image on for a second, more accurate inference. The threshold is held in a staged register that is written through a one-cycle load strobe. Each image uses the staged value that is present on the cycle of its first score, so a load that arrives while an image is in progress takes effect from the next image.

Top module: `margin_judge`

## Requirements
- R1: After reset, res_valid is 0 and the staged threshold is 0.
- R2: res_valid is 1 for exactly the one cycle after a cycle in which score_valid and score_last are both 1, and 0 on every other cycle.
- R3: res_class is the zero-based arrival position, within the image, of the largest score. Scores are compared as two's complement signed values.
- R4: When two or more scores tie for the largest, res_class is the lowest of their positions and res_margin is 0.
- R5: res_margin is the largest score minus the second-largest score, given as an unsigned value SCORE_W+1 bits wide.
- R6: res_confident is 1 exactly when res_margin is strictly greater than the image's threshold. A margin equal to the threshold gives 0.
- R7: With threshold 0, every image whose margin is nonzero is confident. With the all-ones threshold, no image is confident, even for the widest possible margin (2^SCORE_W - 1).
- R8: thr_data is captured into the staged threshold on a cycle where thr_load is 1. An image is judged against the staged value held on the cycle its first score is accepted. A load on that cycle or on a later cycle of the image applies from the next image.
- R9: A new image may start on the cycle right after a last score. The tracking state is cleared for that image with no idle cycle in between.
- R10: Cycles with score_valid at 0 inside an image are ignored. They change neither the positions nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_load | input | 1 | Strobe that writes thr_data into the staged threshold |
| thr_data | input | SCORE_W+1 | New threshold value |
| score_valid | input | 1 | score_data holds a class score |
| score_data | input | SCORE_W | Signed class score |
| score_last | input | 1 | This score is the final one of the image |
| res_valid | output | 1 | Result pulse |
| res_class | output | IDX_W | Position of the largest score |
| res_margin | output | SCORE_W+1 | Largest minus second-largest score |
| res_confident | output | 1 | Margin is strictly above the threshold |

## Verification
Every result appears one clock after the edge that takes in the last score. The bench drives inputs on falling edges. It reads the result on the falling edge that follows the capturing rising edge, before it drives the next image's first score, so back-to-back images are checked at the same point. After each flushed image it reads one more falling edge and expects res_valid to be 0. Threshold loads are tracked in a bench-side staged copy that is frozen at each image's first score. This keeps mid-image loads aligned with the image they are meant to miss.

// File: rtl/margin_judge.sv
module margin_judge #(
  parameter int NUM_CLASSES = 10,
  parameter int SCORE_W = 16,
  localparam int IDX_W = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int MARGIN_W = SCORE_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       thr_load,
  input  logic [MARGIN_W-1:0]        thr_data,
  input  logic                       score_valid,
  input  logic signed [SCORE_W-1:0]  score_data,
  input  logic                       score_last,
  output logic                       res_valid,
  output logic [IDX_W-1:0]           res_class,
  output logic [MARGIN_W-1:0]        res_margin,
  output logic                       res_confident
);

  localparam logic signed [SCORE_W-1:0] MIN_S = {1'b1, {(SCORE_W-1){1'b0}}};

  logic [IDX_W-1:0]          cnt_q, idx_q, nxt_idx;
  logic signed [SCORE_W-1:0] top_q, sec_q, nxt_top, nxt_sec;
  logic [MARGIN_W-1:0]       thr_stage, thr_img, thr_use, margin;
  logic                      first, gt_top, gt_sec, take_last;

  assign first     = (cnt_q == '0);
  assign gt_top    = first || (score_data > top_q);
  assign gt_sec    = !first && (score_data > sec_q);
  assign nxt_top   = gt_top ? score_data : top_q;
  assign nxt_idx   = gt_top ? cnt_q : idx_q;
  assign nxt_sec   = first ? MIN_S : (gt_top ? top_q : (gt_sec ? score_data : sec_q));
  assign thr_use   = first ? thr_stage : thr_img;
  assign margin    = {nxt_top[SCORE_W-1], nxt_top} - {nxt_sec[SCORE_W-1], nxt_sec};
  assign take_last = score_valid && score_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_stage <= '0;
    end else if (thr_load) begin
      thr_stage <= thr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      idx_q   <= '0;
      top_q   <= '0;
      sec_q   <= '0;
      thr_img <= '0;
    end else if (score_valid) begin
      cnt_q <= score_last ? '0 : cnt_q + 1'b1;
      idx_q <= nxt_idx;
      top_q <= nxt_top;
      sec_q <= nxt_sec;
      if (first) thr_img <= thr_stage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid     <= 1'b0;
      res_class     <= '0;
      res_margin    <= '0;
      res_confident <= 1'b0;
    end else begin
      res_valid <= take_last;
      if (take_last) begin
        res_class     <= nxt_idx;
        res_margin    <= margin;
        res_confident <= margin > thr_use;
      end
    end
  end

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_last |=> !res_valid);

  p_class_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_class < IDX_W'(NUM_CLASSES));

  p_tie_keeps_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && !first && score_data == top_q) |=> idx_q == $past(idx_q));

  p_tie_zero_margin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_last && !first && score_data == top_q) |=> (res_margin == '0 && !res_confident));

  p_conf_needs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_confident) |-> res_margin != '0);

  p_ceiling_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_last && (&thr_use)) |=> !res_confident);

  p_stage_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_load |=> $stable(thr_stage));

endmodule

// File: tb/tb_margin_judge.sv
module tb_margin_judge;
  localparam int NC = 10;
  localparam int SW = 16;
  localparam int IW = $clog2(NC);
  localparam int MW = SW + 1;

  logic clk = 0, rst_n = 0;
  logic thr_load = 0, score_valid = 0, score_last = 0;
  logic [MW-1:0] thr_data = '0;
  logic signed [SW-1:0] score_data = '0;
  logic res_valid, res_confident;
  logic [IW-1:0] res_class;
  logic [MW-1:0] res_margin;

  margin_judge #(.NUM_CLASSES(NC), .SCORE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .thr_load(thr_load), .thr_data(thr_data),
    .score_valid(score_valid), .score_data(score_data), .score_last(score_last),
    .res_valid(res_valid), .res_class(res_class), .res_margin(res_margin),
    .res_confident(res_confident));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic signed [SW-1:0] sc [NC];
  logic [MW-1:0] stage_thr = '0;
  bit pend = 0;
  string pend_tag;
  logic [IW-1:0] e_cls;
  logic [MW-1:0] e_mar;
  logic e_conf;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic expect_of(input logic [MW-1:0] thr);
    int best, second;
    best = 0;
    for (int i = 1; i < NC; i++) if (sc[i] > sc[best]) best = i;
    second = -1;
    for (int i = 0; i < NC; i++)
      if (i != best && (second < 0 || sc[i] > sc[second])) second = i;
    e_cls  = IW'(best);
    e_mar  = MW'(int'(sc[best]) - int'(sc[second]));
    e_conf = e_mar > thr;
  endtask

  task automatic do_check();
    chk({pend_tag, " R2 valid"}, 32'(res_valid), 1);
    chk({pend_tag, " R3/R4 class"}, 32'(res_class), 32'(e_cls));
    chk({pend_tag, " R5 margin"}, 32'(res_margin), 32'(e_mar));
    chk({pend_tag, " R6 confident"}, 32'(res_confident), 32'(e_conf));
    pend = 0;
  endtask

  task automatic send_image(input string tag, input bit gaps, input int load_at,
                            input logic [MW-1:0] load_val);
    logic [MW-1:0] img_thr;
    img_thr = stage_thr;
    for (int i = 0; i < NC; i++) begin
      @(negedge clk);
      if (i == 0 && pend) do_check();
      score_valid = 1;
      score_data  = sc[i];
      score_last  = (i == NC - 1);
      thr_load    = (i == load_at);
      thr_data    = load_val;
      if (i == load_at) stage_thr = load_val;
      if (gaps && i < NC - 1 && $urandom_range(0, 2) == 0) begin
        @(negedge clk);
        score_valid = 0;
        score_data  = SW'($urandom);
        score_last  = 1;
        thr_load    = 0;
      end
    end
    expect_of(img_thr);
    pend_tag = tag;
    pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) do_check();
    score_valid = 0;
    score_last  = 0;
    thr_load    = 0;
    @(negedge clk);
    chk("R2 idle after result", 32'(res_valid), 0);
  endtask

  task automatic load_thr(input logic [MW-1:0] v);
    @(negedge clk);
    thr_load = 1;
    thr_data = v;
    stage_thr = v;
    @(negedge clk);
    thr_load = 0;
  endtask

  task automatic fill_ramp(input int base);
    for (int i = 0; i < NC; i++) sc[i] = SW'(base + i * 3);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle valid", 32'(res_valid), 0);
    for (int i = 0; i < NC; i++) sc[i] = SW'(i * 10 - 40);
    sc[3] = 16'sd5;
    send_image("R1 default thr zero", 0, -1, '0);
    flush();

    load_thr(17'd3);
    fill_ramp(-100);
    send_image("R3 ascending", 0, -1, '0);
    flush();

    for (int i = 0; i < NC; i++) sc[i] = -16'sd50;
    sc[2] = 16'sd7; sc[5] = 16'sd7; sc[8] = 16'sd7;
    send_image("R4 three-way tie", 0, -1, '0);
    flush();

    for (int i = 0; i < NC; i++) sc[i] = SW'(-i);
    sc[4] = 16'sd20; sc[7] = 16'sd17;
    send_image("R6 margin equal thr", 0, -1, '0);
    sc[7] = 16'sd16;
    send_image("R6 margin thr plus one", 0, -1, '0);
    flush();

    load_thr('0);
    for (int i = 0; i < NC; i++) sc[i] = SW'(100 - i);
    send_image("R7 zero thr distinct", 0, -1, '0);
    sc[9] = 16'sd100;
    send_image("R7 zero thr tie", 0, -1, '0);
    flush();

    load_thr('1);
    for (int i = 0; i < NC; i++) sc[i] = 16'sh8000;
    sc[6] = 16'sh7fff;
    send_image("R7 all-ones thr widest", 0, -1, '0);
    flush();

    load_thr(17'd50);
    for (int i = 0; i < NC; i++) sc[i] = SW'(i);
    sc[1] = 16'sd100; sc[8] = 16'sd40;
    send_image("R8 old thr midload", 0, 4, 17'd70);
    send_image("R8 new thr next", 0, 0, 17'd10);
    send_image("R8 load at first score", 0, -1, '0);
    flush();

    for (int i = 0; i < NC; i++) sc[i] = SW'(-i * 7);
    send_image("R10 gaps", 1, -1, '0);
    flush();

    for (int n = 0; n < 400; n++) begin
      bit narrow;
      narrow = ($urandom_range(0, 1) == 1);
      for (int i = 0; i < NC; i++)
        sc[i] = narrow ? SW'(int'($urandom_range(0, 7)) - 4) : SW'($urandom);
      if ($urandom_range(0, 3) == 0)
        send_image("R9 random b2b load", $urandom_range(0, 1) == 1,
                   $urandom_range(0, NC - 1),
                   narrow ? MW'($urandom_range(0, 6)) : MW'($urandom));
      else
        send_image("R9 random", $urandom_range(0, 1) == 1, -1, '0);
      if ($urandom_range(0, 4) == 0) flush();
    end
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule